// File: doc/BRIEF.md
# Exception Cause Selector

This unit watches three stages of a five-stage 32-bit RISC pipeline for synchronous faults and also receives one external interrupt line that carries a vector number. From the decode stage it takes an undefined-opcode flag. From the execute stage it takes the signed-overflow flag. From the memory stage it takes the access size and the low address bits, which it uses to find misaligned loads and misaligned stores. In the same cycle it picks one cause and reports it. The output gives the cause code, the handler address and a mask of the pipeline stages to kill. In the following cycle the unit records the program counter of the faulting instruction.

The unit also holds the interrupt-enable state. Software can set this state, clear it, and return from a handler. Taking any exception turns interrupts off and keeps a copy of the previous enable value. A return from exception gives back both the recorded program counter and that copy. The unit accepts only the one request line. Choosing between several interrupting devices is done outside the unit.

Top module: `exc_cause_unit`

## Requirements
- R1: A memory-stage access (`mem_valid`=1) is misaligned according to its size code. Size 0 (byte) is never misaligned. Size 1 (halfword) is misaligned when address bit 0 is 1. Size 2 (word) and size 3 (treated as word) are misaligned when either of the two low address bits is 1. A misaligned load raises cause 1 and a misaligned store raises cause 2, both in the same cycle.
- R2: `ex_valid`&`ex_ovf` raises cause 3 (overflow). `id_valid`&`id_undef` raises cause 4 (undefined instruction). When no cause is present, `exc_take`=0 and `exc_cause`=0.
- R3: When several causes are present in one cycle, the oldest instruction wins. The order is memory stage first, then execute, then decode, then interrupt. The return address recorded is the PC of the winning stage. An interrupt records `id_pc`.
- R4: `exc_vector` depends on the cause. For a trap it is `TRAP_BASE + cause*4`. For an interrupt it is `IRQ_BASE + vector*4`. With the defaults these bases are 0x40 and 0x100.
- R5: The interrupt is taken, with cause 5, only when `irq_req`=1, `irq_en`=1 and `irq_vec` < 60. A vector from 60 to 63 has no effect.
- R6: One cycle after a take, `irq_en` reads 0 and `exc_epc` holds the recorded return address.
- R7: `flush_mask` has one bit per stage: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory. The value depends on the winning source. A memory fault gives 4'b1111, an execute fault 4'b0111, and a decode fault or an interrupt 4'b0011. When nothing is taken the mask is 0.
- R8: `cmd_ei` sets `irq_en` and `cmd_di` clears it, with effect in the next cycle. If both arrive together, `cmd_di` wins. After reset `irq_en`=0 and `exc_epc`=0.
- R9: `cmd_rfe` with no exception being taken gives `ret_take`=1 and `ret_pc`=`exc_epc` in the same cycle. In the next cycle `irq_en` returns to the value it had just before the last take. When an exception is taken in the same cycle, that exception wins and `ret_take`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_valid | input | 1 | Memory stage holds a load or store |
| mem_is_store | input | 1 | 1 = store, 0 = load |
| mem_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| mem_addr_lo | input | 2 | Low two bits of the access address |
| mem_pc | input | 32 | PC of the memory-stage instruction |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_ovf | input | 1 | Signed overflow flag from the ALU |
| ex_pc | input | 32 | PC of the execute-stage instruction |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_undef | input | 1 | Opcode not recognised |
| id_pc | input | 32 | PC of the decode-stage instruction |
| irq_req | input | 1 | External interrupt request |
| irq_vec | input | 6 | Interrupt vector number |
| cmd_ei | input | 1 | Enable-interrupts command |
| cmd_di | input | 1 | Disable-interrupts command |
| cmd_rfe | input | 1 | Return-from-exception command |
| exc_take | output | 1 | An exception is taken this cycle |
| exc_cause | output | 3 | Cause code, 0 none, 1..5 |
| exc_vector | output | 32 | Handler address |
| flush_mask | output | 4 | Stages to kill |
| exc_epc | output | 32 | Recorded return address |
| ret_take | output | 1 | Return from exception is performed |
| ret_pc | output | 32 | Address to resume at |
| irq_en | output | 1 | Interrupt-enable state |

## Verification
The bench builds the unit with its default parameters: 60 vectors in a 6-bit vector field, 4-byte handler spacing and a 32-bit PC. With these values every size code can be combined with every pair of low address bits, for loads and for stores. All 64 values of the vector field can be applied, including the four illegal ones. All 16 combinations of the four fault sources can be driven together, so that priority, flush mask and return address are checked for each. Short command sequences cover the set, clear and restore paths of the enable state.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE     = 3'd0,
      CAUSE_LD_ALIGN = 3'd1,
      CAUSE_ST_ALIGN = 3'd2,
      CAUSE_OVF      = 3'd3,
      CAUSE_UNDEF    = 3'd4,
      CAUSE_IRQ      = 3'd5
   } cause_e;

   localparam int NUM_SIZES = 4;

   // misaligned-bit mask for each size code
   function automatic logic [1:0] size_mask(input int code);
      case (code)
         0:       return 2'b00;
         1:       return 2'b01;
         default: return 2'b11;
      endcase
   endfunction
endpackage

// File: rtl/exc_align_chk.sv
module exc_align_chk
   import exc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       valid,
   input  logic       is_store,
   input  logic [1:0] size,
   input  logic [1:0] addr_lo,
   output logic       ld_fault,
   output logic       st_fault
);
   logic [NUM_SIZES-1:0] hit;
   logic                 misal;

   generate
      for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
         localparam logic [1:0] MASK = size_mask(g);
         assign hit[g] = (size == 2'(g)) && (|(addr_lo & MASK));
      end
   endgenerate

   assign misal    = valid && (|hit);
   assign ld_fault = misal && !is_store;
   assign st_fault = misal &&  is_store;

   // R1: byte accesses never fault
   a_r1_byte_never: assert property (@(posedge clk) disable iff (!rst_n)
      (size == 2'd0) |-> !(ld_fault || st_fault));
   // R1: odd halfword always faults
   a_r1_half_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && size == 2'd1 && addr_lo[0]) |-> (ld_fault || st_fault));
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int          XLEN      = 32,
   parameter int          VW        = 6,
   parameter int          VEC_SHIFT = 2,
   parameter logic [31:0] TRAP_BASE = 32'h0000_0040,
   parameter logic [31:0] IRQ_BASE  = 32'h0000_0100
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_f,
   input  logic            st_f,
   input  logic [XLEN-1:0] mem_pc,
   input  logic            ovf_f,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            undef_f,
   input  logic [XLEN-1:0] id_pc,
   input  logic            irq_ok,
   input  logic [VW-1:0]   irq_vec,
   output logic            take,
   output logic [2:0]      cause,
   output logic [XLEN-1:0] vector,
   output logic [XLEN-1:0] take_pc,
   output logic [3:0]      kill
);
   localparam int NSRC = 4;
   logic [NSRC-1:0] grant;
   logic            mem_f;
   cause_e          c;

   assign mem_f = ld_f || st_f;

   always_comb begin
      grant = '0;
      if      (mem_f)   grant[0] = 1'b1;
      else if (ovf_f)   grant[1] = 1'b1;
      else if (undef_f) grant[2] = 1'b1;
      else if (irq_ok)  grant[3] = 1'b1;
   end

   always_comb begin
      c       = CAUSE_NONE;
      take_pc = '0;
      kill    = 4'b0000;
      if (grant[0]) begin
         c = st_f ? CAUSE_ST_ALIGN : CAUSE_LD_ALIGN;
         take_pc = mem_pc; kill = 4'b1111;
      end else if (grant[1]) begin
         c = CAUSE_OVF;   take_pc = ex_pc; kill = 4'b0111;
      end else if (grant[2]) begin
         c = CAUSE_UNDEF; take_pc = id_pc; kill = 4'b0011;
      end else if (grant[3]) begin
         c = CAUSE_IRQ;   take_pc = id_pc; kill = 4'b0011;
      end
   end

   always_comb begin
      if (grant[3])
         vector = XLEN'(IRQ_BASE) + (XLEN'(irq_vec) << VEC_SHIFT);
      else if (|grant[2:0])
         vector = XLEN'(TRAP_BASE) + (XLEN'(c) << VEC_SHIFT);
      else
         vector = '0;
   end

   assign take  = |grant;
   assign cause = c;

   // R3: at most one source wins
   a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R3: a memory fault always records the memory-stage PC
   a_r3_mem_oldest: assert property (@(posedge clk) disable iff (!rst_n)
      mem_f |-> (take_pc == mem_pc && kill == 4'b1111));
   // R5: the interrupt never displaces a trap
   a_r5_irq_last: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_f || ovf_f || undef_f) |-> (cause != 3'd5));
endmodule

// File: rtl/exc_ie_state.sv
module exc_ie_state #(
   parameter int XLEN = 32
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [XLEN-1:0] take_pc,
   input  logic            cmd_ei,
   input  logic            cmd_di,
   input  logic            cmd_rfe,
   output logic            irq_en,
   output logic [XLEN-1:0] epc,
   output logic            ret_take,
   output logic [XLEN-1:0] ret_pc
);
   logic ie_q, sie_q;
   logic [XLEN-1:0] epc_q;

   assign ret_take = cmd_rfe && !take;
   assign ret_pc   = epc_q;
   assign irq_en   = ie_q;
   assign epc      = epc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         sie_q <= 1'b0;
         epc_q <= '0;
      end else if (take) begin
         sie_q <= ie_q;
         ie_q  <= 1'b0;
         epc_q <= take_pc;
      end else if (cmd_rfe) begin
         ie_q  <= sie_q;
      end else if (cmd_di) begin
         ie_q  <= 1'b0;
      end else if (cmd_ei) begin
         ie_q  <= 1'b1;
      end
   end

   // R6: taking an exception masks interrupts
   a_r6_take_masks: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !irq_en);
   // R6: return address recorded on take
   a_r6_epc_saved: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (epc == $past(take_pc)));
   // R8: disable beats enable
   a_r8_di_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_di && !cmd_rfe && !take) |=> !irq_en);
   // R9: return restores the copied enable
   a_r9_rfe_restore: assert property (@(posedge clk) disable iff (!rst_n)
      ret_take |=> (irq_en == $past(sie_q)));
endmodule

// File: rtl/exc_cause_unit.sv
module exc_cause_unit #(
   parameter int          XLEN      = 32,
   parameter int          VW        = 6,
   parameter int          NUM_VEC   = 60,
   parameter int          VEC_SHIFT = 2,
   parameter logic [31:0] TRAP_BASE = 32'h0000_0040,
   parameter logic [31:0] IRQ_BASE  = 32'h0000_0100
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mem_valid,
   input  logic            mem_is_store,
   input  logic [1:0]      mem_size,
   input  logic [1:0]      mem_addr_lo,
   input  logic [XLEN-1:0] mem_pc,
   input  logic            ex_valid,
   input  logic            ex_ovf,
   input  logic [XLEN-1:0] ex_pc,
   input  logic            id_valid,
   input  logic            id_undef,
   input  logic [XLEN-1:0] id_pc,
   input  logic            irq_req,
   input  logic [VW-1:0]   irq_vec,
   input  logic            cmd_ei,
   input  logic            cmd_di,
   input  logic            cmd_rfe,
   output logic            exc_take,
   output logic [2:0]      exc_cause,
   output logic [XLEN-1:0] exc_vector,
   output logic [3:0]      flush_mask,
   output logic [XLEN-1:0] exc_epc,
   output logic            ret_take,
   output logic [XLEN-1:0] ret_pc,
   output logic            irq_en
);
   localparam logic [VW:0] VLIM = (VW+1)'(NUM_VEC);

   generate
      if (NUM_VEC < 1 || NUM_VEC > (1 << VW)) begin : g_bad_vec
         $error("NUM_VEC must fit the vector field");
      end
      if (XLEN < 8 || VEC_SHIFT < 0 || VEC_SHIFT > 8) begin : g_bad_geom
         $error("unsupported XLEN or VEC_SHIFT");
      end
   endgenerate

   logic ld_f, st_f, ovf_f, undef_f, irq_ok;
   logic [XLEN-1:0] take_pc;

   assign ovf_f   = ex_valid && ex_ovf;
   assign undef_f = id_valid && id_undef;
   assign irq_ok  = irq_req && irq_en && ({1'b0, irq_vec} < VLIM);

   exc_align_chk u_align (
      .clk(clk), .rst_n(rst_n), .valid(mem_valid), .is_store(mem_is_store),
      .size(mem_size), .addr_lo(mem_addr_lo),
      .ld_fault(ld_f), .st_fault(st_f)
   );

   exc_arbiter #(
      .XLEN(XLEN), .VW(VW), .VEC_SHIFT(VEC_SHIFT),
      .TRAP_BASE(TRAP_BASE), .IRQ_BASE(IRQ_BASE)
   ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .ld_f(ld_f), .st_f(st_f), .mem_pc(mem_pc),
      .ovf_f(ovf_f), .ex_pc(ex_pc),
      .undef_f(undef_f), .id_pc(id_pc),
      .irq_ok(irq_ok), .irq_vec(irq_vec),
      .take(exc_take), .cause(exc_cause), .vector(exc_vector),
      .take_pc(take_pc), .kill(flush_mask)
   );

   exc_ie_state #(.XLEN(XLEN)) u_state (
      .clk(clk), .rst_n(rst_n), .take(exc_take), .take_pc(take_pc),
      .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_rfe(cmd_rfe),
      .irq_en(irq_en), .epc(exc_epc), .ret_take(ret_take), .ret_pc(ret_pc)
   );

   // R5: out-of-range vector is never taken as an interrupt
   a_r5_bad_vec: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && ({1'b0, irq_vec} >= VLIM) && !ld_f && !st_f && !ovf_f && !undef_f)
      |-> !exc_take);
   // R5: disabled interrupt is never taken
   a_r5_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en && !ld_f && !st_f && !ovf_f && !undef_f) |-> !exc_take);
   // R9: a take beats a return
   a_r9_take_wins: assert property (@(posedge clk) disable iff (!rst_n)
      exc_take |-> !ret_take);
endmodule

// File: tb/exc_cause_unit_tb_top.sv
module exc_cause_unit_tb_top;
   logic clk = 1'b0;
   logic rst_n;
   logic mem_valid, mem_is_store, ex_valid, ex_ovf, id_valid, id_undef;
   logic irq_req, cmd_ei, cmd_di, cmd_rfe;
   logic [1:0] mem_size, mem_addr_lo;
   logic [31:0] mem_pc, ex_pc, id_pc;
   logic [5:0] irq_vec;
   logic exc_take, ret_take, irq_en;
   logic [2:0] exc_cause;
   logic [3:0] flush_mask;
   logic [31:0] exc_vector, exc_epc, ret_pc;
   int n_chk = 0, n_fail = 0;

   always #10 clk = ~clk;

   exc_cause_unit dut_i (
      .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_is_store(mem_is_store),
      .mem_size(mem_size), .mem_addr_lo(mem_addr_lo), .mem_pc(mem_pc),
      .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
      .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
      .irq_req(irq_req), .irq_vec(irq_vec),
      .cmd_ei(cmd_ei), .cmd_di(cmd_di), .cmd_rfe(cmd_rfe),
      .exc_take(exc_take), .exc_cause(exc_cause), .exc_vector(exc_vector),
      .flush_mask(flush_mask), .exc_epc(exc_epc), .ret_take(ret_take),
      .ret_pc(ret_pc), .irq_en(irq_en)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      mem_valid = 0; mem_is_store = 0; mem_size = 0; mem_addr_lo = 0;
      ex_valid = 0; ex_ovf = 0; id_valid = 0; id_undef = 0;
      irq_req = 0; irq_vec = 0; cmd_ei = 0; cmd_di = 0; cmd_rfe = 0;
      mem_pc = 32'h100; ex_pc = 32'h104; id_pc = 32'h108;
   endtask

   // one clock: inputs were set after a negedge, sample state after posedge
   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic set_ie();
      @(negedge clk); idle(); cmd_ei = 1; tick();
      @(negedge clk); idle();
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(); rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #2;
      // R8 / R2: reset state
      chk("R8 reset irq_en", {31'b0, irq_en}, 0);
      chk("R8 reset epc", exc_epc, 0);
      chk("R2 idle no take", {31'b0, exc_take}, 0);
      chk("R2 idle cause", {29'b0, exc_cause}, 0);

      // R1 / R4 / R7: alignment sweep
      for (int st = 0; st < 2; st++)
         for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 4; a++) begin
               logic f;
               logic [2:0] ec;
               @(negedge clk); idle();
               mem_valid = 1; mem_is_store = st[0]; mem_size = sz[1:0]; mem_addr_lo = a[1:0];
               f = (sz == 1) ? a[0] : (sz >= 2) ? (a != 0) : 1'b0;
               ec = f ? (st ? 3'd2 : 3'd1) : 3'd0;
               #2;
               chk("R1 align take", {31'b0, exc_take}, {31'b0, f});
               chk("R1 align cause", {29'b0, exc_cause}, {29'b0, ec});
               if (f) begin
                  chk("R4 trap vector", exc_vector, 32'h40 + 32'(ec) * 4);
                  chk("R7 mem flush", {28'b0, flush_mask}, 32'hF);
               end
               tick();
               if (f) chk("R6 epc mem", exc_epc, 32'h100);
            end

      // R1: invalid memory stage never faults
      @(negedge clk); idle(); mem_size = 2; mem_addr_lo = 3; #2;
      chk("R1 no valid", {31'b0, exc_take}, 0);

      // R3 / R2 / R6 / R7: all combinations of sources
      for (int k = 0; k < 16; k++) begin
         logic [2:0] ec;
         logic [31:0] epc_e;
         logic [3:0] km;
         set_ie();
         mem_valid = 1; mem_is_store = 1; mem_size = 2; mem_addr_lo = k[0] ? 2'd2 : 2'd0;
         ex_valid = 1; ex_ovf = k[1];
         id_valid = 1; id_undef = k[2];
         irq_req = k[3]; irq_vec = 6'd7;
         if (k[0])      begin ec = 2; epc_e = 32'h100; km = 4'hF; end
         else if (k[1]) begin ec = 3; epc_e = 32'h104; km = 4'h7; end
         else if (k[2]) begin ec = 4; epc_e = 32'h108; km = 4'h3; end
         else if (k[3]) begin ec = 5; epc_e = 32'h108; km = 4'h3; end
         else           begin ec = 0; epc_e = 32'h0;   km = 4'h0; end
         #2;
         chk("R3 priority cause", {29'b0, exc_cause}, {29'b0, ec});
         chk("R7 flush mask", {28'b0, flush_mask}, {28'b0, km});
         if (ec == 5) chk("R4 irq vector", exc_vector, 32'h100 + 7 * 4);
         else if (ec != 0) chk("R4 trap vector", exc_vector, 32'h40 + 32'(ec) * 4);
         tick();
         if (ec != 0) begin
            chk("R6 epc", exc_epc, epc_e);
            chk("R6 ie cleared", {31'b0, irq_en}, 0);
         end else
            chk("R2 ie kept", {31'b0, irq_en}, 1);
      end

      // R5: every vector code with interrupts enabled
      for (int v = 0; v < 64; v++) begin
         logic ok;
         set_ie();
         irq_req = 1; irq_vec = v[5:0]; id_pc = 32'h200 + 32'(v);
         ok = (v < 60);
         #2;
         chk("R5 vector accept", {31'b0, exc_take}, {31'b0, ok});
         if (ok) begin
            chk("R5 irq cause", {29'b0, exc_cause}, 32'd5);
            chk("R4 irq vector", exc_vector, 32'h100 + 32'(v) * 4);
         end
         tick();
         chk("R5 ie after", {31'b0, irq_en}, {31'b0, !ok});
         if (ok) chk("R6 irq epc", exc_epc, 32'h200 + 32'(v));
      end

      // R5 / R8: masked interrupt, di beats ei
      @(negedge clk); idle(); cmd_di = 1; cmd_ei = 1; tick();
      chk("R8 di wins", {31'b0, irq_en}, 0);
      @(negedge clk); idle(); irq_req = 1; irq_vec = 5; #2;
      chk("R5 masked irq", {31'b0, exc_take}, 0);

      // R9: return restores enable=1
      set_ie();
      irq_req = 1; irq_vec = 3; id_pc = 32'h300; tick();
      @(negedge clk); idle(); cmd_rfe = 1; #2;
      chk("R9 ret_take", {31'b0, ret_take}, 1);
      chk("R9 ret_pc", ret_pc, 32'h300);
      tick();
      chk("R9 ie restored 1", {31'b0, irq_en}, 1);

      // R9: return restores enable=0
      @(negedge clk); idle(); cmd_di = 1; tick();
      @(negedge clk); idle(); ex_valid = 1; ex_ovf = 1; ex_pc = 32'h404; tick();
      @(negedge clk); idle(); cmd_ei = 1; tick();
      chk("R8 ei sets", {31'b0, irq_en}, 1);
      @(negedge clk); idle(); cmd_rfe = 1; #2;
      chk("R9 ret_pc trap", ret_pc, 32'h404);
      tick();
      chk("R9 ie restored 0", {31'b0, irq_en}, 0);

      // R9: simultaneous take beats return
      @(negedge clk); idle(); cmd_rfe = 1; id_valid = 1; id_undef = 1; id_pc = 32'h508; #2;
      chk("R9 take wins", {31'b0, ret_take}, 0);
      chk("R9 take wins cause", {29'b0, exc_cause}, 32'd4);
      tick();
      chk("R9 epc from take", exc_epc, 32'h508);

      @(negedge clk); idle();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule